// File: doc/BRIEF.md
# Half to Single Float Widener

This block widens a 16-bit half-precision bit pattern into the 32-bit single-precision pattern of exactly the same value. It keeps the sign, rebiases the exponent, moves the ten fraction bits to the top of the 23-bit fraction field, and turns subnormal halves into normal singles by counting the leading zeros of the fraction and shifting. Every 16-bit input has an exact single-precision equivalent, so the block never rounds.

A mode input chooses how an all-ones input exponent (31) is read. In standard mode it marks infinity or NaN and maps to exponent 0xFF with the fraction carried over. In extended-range mode it is an ordinary finite exponent and is rebiased like any other. There is one register stage: a word presented with `in_valid` high appears one cycle later with `out_valid` high. There is no backpressure.

Top module: `half_widen`

## Requirements
- R1: Output bit 31 equals input bit 15. +0 (0x0000) gives 0x00000000 and -0 (0x8000) gives 0x80000000.
- R2: For an input exponent from 1 to 30, the output exponent (bits 30:23) is the input exponent (bits 14:10) plus 112. Output bits 22:13 equal input bits 9:0, and output bits 12:0 are zero.
- R3: For an input with exponent 0 and a nonzero fraction, let z be the number of leading zeros in the 10-bit fraction. The output exponent is 113 - (z+1), and output bits 22:13 hold the fraction shifted left by z+1, keeping the low 10 bits. The output value equals fraction x 2^-24.
- R4: When `ieee_mode`=1 and the input exponent is 31, the output exponent is 0xFF and output bits 22:13 equal the input fraction. Infinity stays infinity and NaN stays NaN.
- R5: When `ieee_mode`=0 and the input exponent is 31, the output exponent is 143 (0x8F) and the fraction is carried over as in R2. For inputs with exponent below 31, the mode bit has no effect.
- R6: `out_valid` equals `in_valid` delayed by exactly one clock. The output word is loaded only in a cycle where `in_valid` is high, and it holds its value otherwise.
- R7: A synchronous reset clears `out_valid` and `out_word` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word qualifier |
| ieee_mode | input | 1 | 1: exponent 31 is inf/NaN; 0: exponent 31 is finite |
| in_half | input | 16 | Half-precision bit pattern |
| out_valid | output | 1 | Output word qualifier |
| out_word | output | 32 | Single-precision bit pattern |

## Verification
The conversion is driven with both signed zeros, normal values at the lowest, a middle and the highest finite exponent, and subnormals whose leading one sits at every one of the ten fraction positions. This separates an error in the shift count from an error in the exponent correction. Infinity and a NaN payload are each sent in both modes, which separates the two readings of exponent 31, and the same normal value is sent in both modes to show the mode bit has no effect there. Gaps in `in_valid` with changing data, and a reset issued mid-stream, check the latency, the hold behaviour and the cleared state.

// File: rtl/half_widen.sv
module half_widen #(
  parameter int HW = 16,
  parameter int EW = 5,
  parameter int SW = 32,
  parameter int SEW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          ieee_mode,
  input  logic [HW-1:0] in_half,
  output logic          out_valid,
  output logic [SW-1:0] out_word
);
  localparam int MW  = HW - 1 - EW;
  localparam int SMW = SW - 1 - SEW;
  localparam int REB = (1 << (SEW-1)) - (1 << (EW-1));
  localparam int CW  = $clog2(MW + 1);

  logic          sgn;
  logic [EW-1:0] ex;
  logic [MW-1:0] fr;
  assign sgn = in_half[HW-1];
  assign ex  = in_half[HW-2:MW];
  assign fr  = in_half[MW-1:0];

  logic [CW-1:0] lz;
  always_comb begin
    lz = CW'(MW);
    for (int i = 0; i < MW; i++)
      if (fr[i]) lz = CW'(MW - 1 - i);
  end

  logic [MW-1:0]  nfr;
  logic [SEW-1:0] nex;
  logic [SW-1:0]  res;
  always_comb begin
    nfr = fr;
    nex = SEW'(ex) + SEW'(REB);
    if (ex == '0) begin
      if (fr == '0) begin
        nex = '0;
      end else begin
        nfr = fr << (lz + 1'b1);
        nex = SEW'(REB) - SEW'(lz);
      end
    end else if (&ex && ieee_mode) begin
      nex = '1;
    end
    res = {sgn, nex, nfr, {(SMW-MW){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= res;
    end
  end

  AST_SIGN_COPY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_word[SW-1] == $past(in_half[HW-1]));  // R1
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_word[SMW-MW-1:0] == '0);  // R2
  AST_SUBN_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ex == '0 && fr != '0) |=> (out_word[SW-2:SMW] != '0 && out_word[SW-2:SMW] <= SEW'(REB)));  // R3
  AST_IEEE_SPECIAL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ieee_mode && &ex) |=> &out_word[SW-2:SMW]);  // R4
  AST_ALT_FINITE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !ieee_mode) |=> !(&out_word[SW-2:SMW]));  // R5
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid));  // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_word));  // R6
  AST_RESET_CLR: assert property (@(posedge clk)
    rst |=> (!out_valid && out_word == '0));  // R7
endmodule

// File: tb/test_half_widen.sv
module test_half_widen;
  logic clk = 0, rst = 1, in_valid = 0, ieee_mode = 1;
  logic [15:0] in_half = '0;
  logic out_valid;
  logic [31:0] out_word;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  half_widen i_half_widen (.clk(clk), .rst(rst), .in_valid(in_valid), .ieee_mode(ieee_mode),
    .in_half(in_half), .out_valid(out_valid), .out_word(out_word));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic conv(input logic m, input logic [15:0] h, input logic [31:0] exp, input string req);
    @(posedge clk); #1;
    in_valid = 1; ieee_mode = m; in_half = h;
    @(posedge clk); #1;
    in_valid = 0;
    chk(req, {31'd0, out_valid}, 32'd1);
    chk(req, out_word, exp);
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (2) @(posedge clk);
    #1;
    chk("R7 valid", {31'd0, out_valid}, 0);
    chk("R7 word", out_word, 0);
    rst = 0;
  endtask

  task automatic t_zero;
    conv(1, 16'h0000, 32'h0000_0000, "R1 +0");
    conv(1, 16'h8000, 32'h8000_0000, "R1 -0");
  endtask

  task automatic t_normal;
    conv(1, 16'h3C00, 32'h3F80_0000, "R2 one");
    conv(1, 16'hC000, 32'hC000_0000, "R2 minus two");
    conv(1, 16'h0400, 32'h3880_0000, "R2 min normal");
    conv(1, 16'h7BFF, 32'h477F_E000, "R2 max finite");
    conv(1, 16'h3555, 32'h3EAA_A000, "R2 pattern");
    conv(0, 16'h3555, 32'h3EAA_A000, "R5 mode ignored");
  endtask

  task automatic t_subn;
    for (int p = 0; p < 10; p++) begin
      logic [9:0] f;
      logic [9:0] nf;
      logic [7:0] e;
      f = 10'(1) << p;
      f = f | (10'h3FF >> (10 - p));
      nf = f << (10 - p);
      e = 8'(103 + p);
      conv(1, {1'b0, 5'd0, f}, {1'b0, e, nf, 13'd0}, "R3 subnormal");
    end
    conv(1, 16'h8001, 32'hB380_0000, "R3 neg min subnormal");
  endtask

  task automatic t_special;
    conv(1, 16'h7C00, 32'h7F80_0000, "R4 +inf");
    conv(1, 16'hFC00, 32'hFF80_0000, "R4 -inf");
    conv(1, 16'h7E01, 32'h7FC0_2000, "R4 nan");
    conv(0, 16'h7C00, 32'h4780_0000, "R5 alt exp31");
    conv(0, 16'hFFFF, 32'hC7FF_E000, "R5 alt max");
  endtask

  task automatic t_hold;
    conv(1, 16'h3C00, 32'h3F80_0000, "R6 load");
    in_half = 16'h4000;
    @(posedge clk); #1;
    chk("R6 no valid", {31'd0, out_valid}, 0);
    chk("R6 hold", out_word, 32'h3F80_0000);
    @(posedge clk); #1;
    chk("R6 hold2", out_word, 32'h3F80_0000);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_zero();
    t_normal();
    t_subn();
    t_special();
    t_hold();
    @(posedge clk); #1;
    in_valid = 1; in_half = 16'h3C00;
    t_reset();
    in_valid = 0;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule